// File: doc/BRIEF.md
# Power-Management Function Configuration Space with I/O Window Decode

This block holds the 256-byte configuration space of a function that answers on two I/O windows: a 64-byte power-management window and a 16-byte SMBus window. Configuration software reads and writes the space one 32-bit word at a time. Each byte lane has its own enable, and every lane passes through a write policy before it is stored. Some byte ranges refuse writes. The command byte accepts only its I/O-enable bit. The low byte of each window base register is reshaped: its alignment bits are cleared and its I/O-space flag bit is set.

From the stored base registers and enable bits, the block decodes an incoming 16-bit I/O address into two hit signals, one for each window. Each hit is gated by a different configuration bit. When a write actually changes a stored byte of a base register, the block raises a one-cycle pulse for that window, so the surrounding logic can re-map the window.

Top module: `pmio_cfg_space`

## Requirements
- R1: After reset, every byte reads 0x00 except these: offset 0x06 = 0x80, 0x07 = 0x02, 0x40 = 0x01, 0x90 = 0x01, 0x5F = 0x90, 0x63 = 0x60 and 0x67 = 0x98.
- R2: Writes to any byte from offset 0x10 to 0x33 inclusive leave that byte unchanged.
- R3: At offset 0x04, a write changes only bit 0, the I/O enable. Bits 7:1 keep their previous value.
- R4: Writes to offset 0x06 leave it unchanged. Offset 0x07 is written as-is.
- R5: A write to offset 0x40, the low byte of the PM base, stores (data & 0xC0) | 0x01. Offsets 0x41 to 0x43 store the data unchanged.
- R6: A write to offset 0x90, the low byte of the SMBus base, stores (data & 0xF0) | 0x01. Offsets 0x91 to 0x93 store the data unchanged.
- R7: Word address w covers byte offsets 4w to 4w+3. Byte 4w+k sits on data bits 8k+7:8k and is written only when byte enable k is set. All enabled lanes are updated in the same cycle. Bytes not named in R2 to R6 store the data as written, and cfg_rdata shows the addressed word combinationally.
- R8: pm_hit is 1 exactly when bit 0 of offset 0x80 is 1 and (io_addr & 0xFFC0) equals ({byte 0x41, byte 0x40} & 0xFFC0).
- R9: sm_hit is 1 exactly when bit 0 of offset 0x04 or bit 0 of offset 0xD2 is 1, and (io_addr & 0xFFF0) equals ({byte 0x91, byte 0x90} & 0xFFF0).
- R10: pm_base_moved is 1 for the single cycle after a write edge only if that write changed the stored value of at least one byte from 0x40 to 0x43. A write that stores the same value raises no pulse.
- R11: sm_base_moved follows the same rule as R10 for bytes 0x90 to 0x93.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the addressed word |
| cfg_word | input | 6 | Word address into the configuration space |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data, lane k on bits 8k+7:8k |
| cfg_rdata | output | 32 | Combinational read data of the addressed word |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled PM window |
| sm_hit | output | 1 | Address falls in the enabled SMBus window |
| pm_base_moved | output | 1 | One-cycle pulse after a PM base change |
| sm_base_moved | output | 1 | One-cycle pulse after an SMBus base change |

## Verification
On every cycle, the assertions check five things:
- the I/O-space flag in both stored bases stays set;
- the status byte keeps its fixed value whenever it is addressed;
- a hit only occurs when the address matches the aligned base;
- any change of a stored base comes with its pulse;
- a pulse is always preceded by a write.

Only the directed scenarios can show:
- the exact reset image;
- the value stored under each lane policy;
- that a rewrite of an identical base value stays silent;
- that an out-of-window address misses;
- that the SMBus window needs one of its two enable bits.

// File: rtl/pmio_cfg_pkg.sv
package pmio_cfg_pkg;

    localparam int unsigned CFG_BYTES = 256;
    localparam int unsigned LANES     = 4;
    localparam int unsigned WORD_AW   = $clog2(CFG_BYTES / LANES);
    localparam int unsigned IO_AW     = 16;
    localparam int unsigned PM_SPAN   = 64;
    localparam int unsigned SM_SPAN   = 16;

    localparam logic [7:0] OFS_CMD       = 8'h04;
    localparam logic [7:0] OFS_STAT_LO   = 8'h06;
    localparam logic [7:0] OFS_STAT_HI   = 8'h07;
    localparam logic [7:0] OFS_RO_FIRST  = 8'h10;
    localparam logic [7:0] OFS_RO_LAST   = 8'h33;
    localparam logic [7:0] OFS_PM_BASE   = 8'h40;
    localparam logic [7:0] OFS_PM_EN     = 8'h80;
    localparam logic [7:0] OFS_SM_BASE   = 8'h90;
    localparam logic [7:0] OFS_SM_ALT_EN = 8'hD2;

    // Alignment masks for the low base byte, derived from window spans
    localparam logic [7:0] PM_LO_MASK = 8'(256 - PM_SPAN);
    localparam logic [7:0] SM_LO_MASK = 8'(256 - SM_SPAN);
    localparam logic [7:0] IO_SPACE_FLAG = 8'h01;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_PM   = 2'd1,
        WIN_SM   = 2'd2
    } win_e;

    typedef struct packed {
        logic [7:0] val;    // value to store
        logic       we;     // store differs from old
        logic       moved;  // base byte changed
        win_e       win;    // which base (if any) the byte belongs to
    } lane_res_t;

    function automatic logic [7:0] reset_value(input logic [7:0] ofs);
        logic [7:0] v;
        case (ofs)
            OFS_STAT_LO: v = 8'h80;
            OFS_STAT_HI: v = 8'h02;
            OFS_PM_BASE: v = IO_SPACE_FLAG;
            OFS_SM_BASE: v = IO_SPACE_FLAG;
            8'h5F:       v = 8'h90;
            8'h63:       v = 8'h60;
            8'h67:       v = 8'h98;
            default:     v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic win_e base_window(input logic [7:0] ofs);
        win_e w;
        if (ofs[7:2] == OFS_PM_BASE[7:2])      w = WIN_PM;
        else if (ofs[7:2] == OFS_SM_BASE[7:2]) w = WIN_SM;
        else                                   w = WIN_NONE;
        return w;
    endfunction

    function automatic lane_res_t shape_byte(input logic [7:0] ofs,
                                             input logic [7:0] old,
                                             input logic [7:0] din,
                                             input logic       en);
        lane_res_t r;
        r.val   = old;
        r.we    = 1'b0;
        r.moved = 1'b0;
        r.win   = base_window(ofs);
        if (en) begin
            if ((ofs >= OFS_RO_FIRST && ofs <= OFS_RO_LAST) || ofs == OFS_STAT_LO)
                r.val = old;
            else if (ofs == OFS_CMD)
                r.val = {old[7:1], din[0]};
            else if (ofs == OFS_PM_BASE)
                r.val = (din & PM_LO_MASK) | IO_SPACE_FLAG;
            else if (ofs == OFS_SM_BASE)
                r.val = (din & SM_LO_MASK) | IO_SPACE_FLAG;
            else
                r.val = din;
            r.we    = (r.val != old);
            r.moved = r.we && (r.win != WIN_NONE);
        end
        return r;
    endfunction

endpackage

// File: rtl/pmio_lane_shaper.sv
module pmio_lane_shaper
    import pmio_cfg_pkg::*;
#(
    parameter int unsigned LANE = 0
) (
    input  logic [WORD_AW-1:0] word,
    input  logic               wr,
    input  logic               be,
    input  logic [7:0]         din,
    input  logic [7:0]         old,
    output lane_res_t          res
);
    logic [7:0] ofs;

    always_comb begin
        ofs = 8'(int'(word) * LANES + LANE);
        res = shape_byte(ofs, old, din, wr && be);
    end
endmodule

// File: rtl/pmio_byte_store.sv
module pmio_byte_store
    import pmio_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WORD_AW-1:0]   word,
    input  logic [LANES-1:0]     lane_we,
    input  logic [LANES*8-1:0]   lane_val,
    output logic [LANES*8-1:0]   word_data,
    output logic [IO_AW-1:0]     pm_base16,
    output logic [IO_AW-1:0]     sm_base16,
    output logic                 pm_dec_en,
    output logic                 sm_dec_en
);
    logic [7:0] mem [CFG_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++)
                mem[i] <= reset_value(8'(i));
        end else begin
            for (int k = 0; k < LANES; k++)
                if (lane_we[k])
                    mem[int'(word) * LANES + k] <= lane_val[k*8 +: 8];
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++)
            word_data[k*8 +: 8] = mem[int'(word) * LANES + k];
        pm_base16 = {mem[int'(OFS_PM_BASE) + 1], mem[int'(OFS_PM_BASE)]};
        sm_base16 = {mem[int'(OFS_SM_BASE) + 1], mem[int'(OFS_SM_BASE)]};
        pm_dec_en = mem[int'(OFS_PM_EN)][0];
        sm_dec_en = mem[int'(OFS_CMD)][0] | mem[int'(OFS_SM_ALT_EN)][0];
    end
endmodule

// File: rtl/pmio_window_decode.sv
module pmio_window_decode
    import pmio_cfg_pkg::*;
#(
    parameter int unsigned SPAN = 64
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_AW-1:0] base,
    input  logic             en,
    output logic             hit
);
    localparam logic [IO_AW-1:0] ALIGN_MASK = IO_AW'((1 << IO_AW) - SPAN);

    always_comb hit = en && ((io_addr & ALIGN_MASK) == (base & ALIGN_MASK));
endmodule

// File: rtl/pmio_cfg_space.sv
module pmio_cfg_space
    import pmio_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [WORD_AW-1:0]   cfg_word,
    input  logic [LANES-1:0]     cfg_be,
    input  logic [LANES*8-1:0]   cfg_wdata,
    output logic [LANES*8-1:0]   cfg_rdata,
    input  logic [IO_AW-1:0]     io_addr,
    output logic                 pm_hit,
    output logic                 sm_hit,
    output logic                 pm_base_moved,
    output logic                 sm_base_moved
);
    lane_res_t              lane_res [LANES];
    logic [LANES-1:0]       lane_we;
    logic [LANES*8-1:0]     lane_val;
    logic [LANES-1:0]       pm_mv, sm_mv;
    logic [IO_AW-1:0]       pm_base16, sm_base16;
    logic                   pm_dec_en, sm_dec_en;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pmio_lane_shaper #(.LANE(k)) u_shape (
            .word (cfg_word),
            .wr   (cfg_wr),
            .be   (cfg_be[k]),
            .din  (cfg_wdata[k*8 +: 8]),
            .old  (cfg_rdata[k*8 +: 8]),
            .res  (lane_res[k])
        );
        always_comb begin
            lane_we[k]            = lane_res[k].we;
            lane_val[k*8 +: 8]    = lane_res[k].val;
            pm_mv[k] = lane_res[k].moved && (lane_res[k].win == WIN_PM);
            sm_mv[k] = lane_res[k].moved && (lane_res[k].win == WIN_SM);
        end
    end

    pmio_byte_store u_store (
        .clk       (clk),
        .rst       (rst),
        .word      (cfg_word),
        .lane_we   (lane_we),
        .lane_val  (lane_val),
        .word_data (cfg_rdata),
        .pm_base16 (pm_base16),
        .sm_base16 (sm_base16),
        .pm_dec_en (pm_dec_en),
        .sm_dec_en (sm_dec_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_base_moved <= 1'b0;
            sm_base_moved <= 1'b0;
        end else begin
            pm_base_moved <= |pm_mv;
            sm_base_moved <= |sm_mv;
        end
    end

    pmio_window_decode #(.SPAN(PM_SPAN)) u_pm_dec (
        .io_addr (io_addr),
        .base    (pm_base16),
        .en      (pm_dec_en),
        .hit     (pm_hit)
    );

    pmio_window_decode #(.SPAN(SM_SPAN)) u_sm_dec (
        .io_addr (io_addr),
        .base    (sm_base16),
        .en      (sm_dec_en),
        .hit     (sm_hit)
    );
endmodule

// File: rtl/pmio_cfg_space_chk.sv
module pmio_cfg_space_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [5:0]  cfg_word,
    input logic [31:0] cfg_rdata,
    input logic [15:0] io_addr,
    input logic        pm_hit,
    input logic        sm_hit,
    input logic        pm_base_moved,
    input logic        sm_base_moved,
    input logic [15:0] pm_base16,
    input logic [15:0] sm_base16
);
    a_r5_pm_io_flag: assert property (@(posedge clk) disable iff (rst)
        pm_base16[0]);
    a_r6_sm_io_flag: assert property (@(posedge clk) disable iff (rst)
        sm_base16[0]);
    a_r4_status_fixed: assert property (@(posedge clk) disable iff (rst)
        (cfg_word == 6'd1) |-> (cfg_rdata[23:16] == 8'h80));
    a_r8_pm_hit_range: assert property (@(posedge clk) disable iff (rst)
        pm_hit |-> (io_addr[15:6] == pm_base16[15:6]));
    a_r9_sm_hit_range: assert property (@(posedge clk) disable iff (rst)
        sm_hit |-> (io_addr[15:4] == sm_base16[15:4]));
    a_r10_pm_change_pulses: assert property (@(posedge clk) disable iff (rst)
        !$stable(pm_base16) |-> pm_base_moved);
    a_r10_pm_pulse_needs_write: assert property (@(posedge clk) disable iff (rst)
        pm_base_moved |-> $past(cfg_wr));
    a_r11_sm_change_pulses: assert property (@(posedge clk) disable iff (rst)
        !$stable(sm_base16) |-> sm_base_moved);
    a_r11_sm_pulse_needs_write: assert property (@(posedge clk) disable iff (rst)
        sm_base_moved |-> $past(cfg_wr));
endmodule

bind pmio_cfg_space pmio_cfg_space_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_word      (cfg_word),
    .cfg_rdata     (cfg_rdata),
    .io_addr       (io_addr),
    .pm_hit        (pm_hit),
    .sm_hit        (sm_hit),
    .pm_base_moved (pm_base_moved),
    .sm_base_moved (sm_base_moved),
    .pm_base16     (pm_base16),
    .sm_base16     (sm_base16)
);

// File: tb/pmio_cfg_space_tb_top.sv
module pmio_cfg_space_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_word = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        pm_hit, sm_hit, pm_base_moved, sm_base_moved;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pmio_cfg_space dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .pm_hit(pm_hit), .sm_hit(sm_hit),
        .pm_base_moved(pm_base_moved), .sm_base_moved(sm_base_moved)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; on return the write edge has passed and
    // the base-change pulses are visible.
    task automatic wr(input logic [5:0] w, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word = w; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] w, input logic [31:0] exp);
        cfg_word = w;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic hit_check(input string req, input logic [15:0] a,
                             input logic exp_pm, input logic exp_sm);
        io_addr = a;
        #1;
        check({req, " pm_hit"}, 32'(pm_hit), 32'(exp_pm));
        check({req, " sm_hit"}, 32'(sm_hit), 32'(exp_sm));
    endtask

    task automatic t_reset;
        rd_check("R1 cmd/status word", 6'h01, 32'h0280_0000);
        rd_check("R1 irq word 0x3C",    6'h0F, 32'h0000_0000);
        rd_check("R1 pm base",          6'h10, 32'h0000_0001);
        rd_check("R1 0x58 word",        6'h16, 32'h0000_0000);
        rd_check("R1 0x5C word",        6'h17, 32'h9000_0000);
        rd_check("R1 0x60 word",        6'h18, 32'h6000_0000);
        rd_check("R1 0x64 word",        6'h19, 32'h9800_0000);
        rd_check("R1 sm base",          6'h24, 32'h0000_0001);
        check("R10 no pulse at reset", 32'(pm_base_moved), 32'd0);
        check("R11 no pulse at reset", 32'(sm_base_moved), 32'd0);
        hit_check("R8 R9 disabled at reset", 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_readonly;
        wr(6'h04, 4'hF, 32'hFFFF_FFFF);
        rd_check("R2 offset 0x10", 6'h04, 32'h0000_0000);
        wr(6'h0C, 4'hF, 32'hFFFF_FFFF);
        rd_check("R2 offset 0x30", 6'h0C, 32'h0000_0000);
        wr(6'h0D, 4'hF, 32'hA5A5_5A5A);
        rd_check("R7 offset 0x34 writable", 6'h0D, 32'hA5A5_5A5A);
    endtask

    task automatic t_cmd_status;
        wr(6'h01, 4'hF, 32'hFFFF_FFFF);
        rd_check("R3 R4 cmd/status all ones", 6'h01, 32'hFF80_FF01);
        wr(6'h01, 4'b0001, 32'h0000_0000);
        rd_check("R3 cmd bit0 cleared", 6'h01, 32'hFF80_FF00);
    endtask

    task automatic t_pm_base;
        wr(6'h10, 4'hF, 32'h1234_ABFF);
        check("R10 pulse on pm change", 32'(pm_base_moved), 32'd1);
        check("R11 no sm pulse on pm write", 32'(sm_base_moved), 32'd0);
        rd_check("R5 pm base shaped", 6'h10, 32'h1234_ABC1);
        @(negedge clk);
        check("R10 pulse lasts one cycle", 32'(pm_base_moved), 32'd0);
        wr(6'h10, 4'hF, 32'h1234_ABFF);
        check("R10 same value no pulse", 32'(pm_base_moved), 32'd0);
        wr(6'h10, 4'b1000, 32'h5600_0000);
        check("R10 pulse on high byte", 32'(pm_base_moved), 32'd1);
        rd_check("R5 upper byte as-is", 6'h10, 32'h5634_ABC1);
    endtask

    task automatic t_sm_base;
        wr(6'h24, 4'hF, 32'h0000_C07F);
        check("R11 pulse on sm change", 32'(sm_base_moved), 32'd1);
        check("R10 no pm pulse on sm write", 32'(pm_base_moved), 32'd0);
        rd_check("R6 sm base shaped", 6'h24, 32'h0000_C071);
        wr(6'h24, 4'b0001, 32'h0000_0070);
        check("R11 reshaped equal no pulse", 32'(sm_base_moved), 32'd0);
    endtask

    task automatic t_byte_enable;
        wr(6'h20, 4'b0001, 32'hAAAA_AA01);
        rd_check("R7 single lane", 6'h20, 32'h0000_0001);
        wr(6'h21, 4'b1010, 32'h1122_3344);
        rd_check("R7 lanes 1 and 3", 6'h21, 32'h1100_3300);
    endtask

    task automatic t_pm_hit;
        wr(6'h10, 4'b0011, 32'h0000_AB40);
        hit_check("R8 base address", 16'hAB40, 1'b1, 1'b0);
        hit_check("R8 last in window", 16'hAB7F, 1'b1, 1'b0);
        hit_check("R8 above window", 16'hAB80, 1'b0, 1'b0);
        hit_check("R8 below window", 16'hAB3F, 1'b0, 1'b0);
        wr(6'h20, 4'b0001, 32'h0000_0000);
        hit_check("R8 enable off", 16'hAB40, 1'b0, 1'b0);
    endtask

    task automatic t_sm_hit;
        hit_check("R9 both enables off", 16'hC07F, 1'b0, 1'b0);
        wr(6'h34, 4'b0100, 32'h0001_0000);
        hit_check("R9 alt enable", 16'hC07F, 1'b0, 1'b1);
        hit_check("R9 outside window", 16'hC080, 1'b0, 1'b0);
        wr(6'h34, 4'b0100, 32'h0000_0000);
        wr(6'h01, 4'b0001, 32'h0000_0001);
        hit_check("R9 command enable", 16'hC070, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readonly();
        t_cmd_status();
        t_pm_base();
        t_sm_base();
        t_byte_enable();
        t_pm_hit();
        t_sm_hit();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule